// File: doc/BRIEF.md
# Instruction Address Sequencer with Upper-Bits Latch

This block holds the 15-bit instruction address of a small 8-bit processor core whose instructions are 14 bits wide. On every enabled instruction cycle it moves to the next address. In place of that step it can take a vector on an interrupt, a software load of the low byte, or an indexed jump that adds the 8-bit working register to the address of the next instruction.

Software never writes the upper seven address bits directly. It writes them into a buffer register first. A later write of the low byte moves the buffer and the new low byte into the counter together, so the full address changes in one cycle. The program store holds only 8,192 words, so the fetch address keeps only the low 13 bits of the counter. Higher addresses fold onto the implemented space.

The core's decoder drives the control strobes, one instruction cycle per asserted `step_en`. The fetch address goes straight to the program store.

Top module: `pcx_program_counter`

## Requirements
- R1: When `rst` is high at a clock edge, the counter becomes 0000h and the upper-bits buffer becomes 00h. The outputs then read `pc_full`=0000h, `pc_lo`=00h and `fetch_addr`=0000h.
- R2: In an enabled cycle with no vector, no low-byte write and no jump, the counter increases by one. In a cycle with `step_en` low, nothing changes.
- R3: Stepping or jumping beyond 7FFFh keeps only 15 bits, so 7FFFh steps to 0000h.
- R4: `fetch_addr` equals bits 12:0 of the counter, so for example 2005h fetches from 0005h and 7FFFh fetches from 1FFFh.
- R5: Writing the upper-bits buffer alone does not alter the counter's normal step.
- R6: A low-byte write loads counter bits 7:0 from `lo_wdata` and bits 14:8 from the buffer, in the same cycle.
- R7: If the buffer and the low byte are written in the same cycle, the low-byte write uses the buffer value from before that cycle. The new buffer value is used by the next low-byte write.
- R8: An indexed jump sets the counter to (counter + 1 + unsigned `wreg`) modulo 2^15.
- R9: An interrupt request loads 0004h. It takes priority over a low-byte write and a jump in the same cycle.
- R10: A low-byte write takes priority over a jump in the same cycle.
- R11: `pc_lo` always shows counter bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Instruction cycle enable; qualifies every update |
| lo_we | input | 1 | Write strobe for the low address byte |
| lo_wdata | input | 8 | Data for the low address byte |
| hi_we | input | 1 | Write strobe for the upper-bits buffer |
| hi_wdata | input | 7 | Data for the upper-bits buffer |
| jmp_rel | input | 1 | Indexed jump request |
| wreg | input | 8 | Working register value added on a jump |
| irq_take | input | 1 | Interrupt vector request |
| pc_full | output | 15 | Current counter value |
| pc_lo | output | 8 | Low byte of the counter, for register reads |
| fetch_addr | output | 13 | Address presented to the program store |

## Verification
A wrong buffer value does not show while the counter is only stepping. It appears in `pc_full` at the first low-byte write after the fault, one clock after that write, which is why the tests always follow a buffer write with a low-byte load. A wrong choice of source, such as a swapped priority or a jump that omits the +1, shows in `pc_full` and `fetch_addr` on the clock right after the cycle that made it. A fault in the 13-bit fold shows only on counters of 2000h and above, so those addresses are driven on purpose.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
  localparam int PCX_PC_W   = 15;
  localparam int PCX_MEM_AW = 13;
  localparam int PCX_BYTE_W = 8;
  localparam int PCX_IRQ_VEC = 4;
  localparam int PCX_RST_VEC = 0;

  typedef enum logic [2:0] {
    SRC_HOLD,
    SRC_VEC,
    SRC_LOW,
    SRC_REL,
    SRC_INC
  } pcx_src_e;
endpackage

// File: rtl/pcx_hi_latch.sv
module pcx_hi_latch #(
  parameter int HI_W = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step_en,
  input  logic            we,
  input  logic [HI_W-1:0] wdata,
  output logic [HI_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (step_en && we) q <= wdata;
  end

  // R5
  buf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(step_en && we) |=> $stable(q));
  // R1
  buf_rst_chk: assert property (@(posedge clk) rst |=> q == '0);
endmodule

// File: rtl/pcx_next_sel.sv
module pcx_next_sel
  import pcx_pkg::*;
#(
  parameter int PC_W    = PCX_PC_W,
  parameter int BYTE_W  = PCX_BYTE_W,
  parameter int IRQ_VEC = PCX_IRQ_VEC
) (
  input  logic [PC_W-1:0]        pc,
  input  logic [PC_W-BYTE_W-1:0] hi_buf,
  input  logic                   step_en,
  input  logic                   irq_take,
  input  logic                   lo_we,
  input  logic [BYTE_W-1:0]      lo_wdata,
  input  logic                   jmp_rel,
  input  logic [BYTE_W-1:0]      wreg,
  output pcx_src_e               src,
  output logic [PC_W-1:0]        nxt
);
  logic [PC_W-1:0] seq_addr;
  logic [PC_W-1:0] rel_addr;

  assign seq_addr = pc + PC_W'(1);
  assign rel_addr = seq_addr + PC_W'(wreg);

  always_comb begin
    if (!step_en)      src = SRC_HOLD;
    else if (irq_take) src = SRC_VEC;
    else if (lo_we)    src = SRC_LOW;
    else if (jmp_rel)  src = SRC_REL;
    else               src = SRC_INC;
  end

  always_comb begin
    case (src)
      SRC_VEC:  nxt = PC_W'(IRQ_VEC);
      SRC_LOW:  nxt = {hi_buf, lo_wdata};
      SRC_REL:  nxt = rel_addr;
      SRC_INC:  nxt = seq_addr;
      default:  nxt = pc;
    endcase
  end
endmodule

// File: rtl/pcx_pc_reg.sv
module pcx_pc_reg #(
  parameter int PC_W    = 15,
  parameter int RST_VEC = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] nxt,
  output logic [PC_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= PC_W'(RST_VEC);
    else     q <= nxt;
  end

  // R1
  pc_rst_chk: assert property (@(posedge clk) rst |=> q == PC_W'(RST_VEC));
endmodule

// File: rtl/pcx_program_counter.sv
module pcx_program_counter
  import pcx_pkg::*;
#(
  parameter int PC_W    = PCX_PC_W,
  parameter int MEM_AW  = PCX_MEM_AW,
  parameter int BYTE_W  = PCX_BYTE_W,
  parameter int IRQ_VEC = PCX_IRQ_VEC,
  parameter int RST_VEC = PCX_RST_VEC
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   step_en,
  input  logic                   lo_we,
  input  logic [BYTE_W-1:0]      lo_wdata,
  input  logic                   hi_we,
  input  logic [PC_W-BYTE_W-1:0] hi_wdata,
  input  logic                   jmp_rel,
  input  logic [BYTE_W-1:0]      wreg,
  input  logic                   irq_take,
  output logic [PC_W-1:0]        pc_full,
  output logic [BYTE_W-1:0]      pc_lo,
  output logic [MEM_AW-1:0]      fetch_addr
);
  localparam int HI_W = PC_W - BYTE_W;

  logic [HI_W-1:0] hi_buf;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_nxt;
  pcx_src_e        src;

  pcx_hi_latch #(.HI_W(HI_W)) u_hi (
    .clk(clk), .rst(rst), .step_en(step_en),
    .we(hi_we), .wdata(hi_wdata), .q(hi_buf)
  );

  pcx_next_sel #(.PC_W(PC_W), .BYTE_W(BYTE_W), .IRQ_VEC(IRQ_VEC)) u_sel (
    .pc(pc_q), .hi_buf(hi_buf), .step_en(step_en), .irq_take(irq_take),
    .lo_we(lo_we), .lo_wdata(lo_wdata), .jmp_rel(jmp_rel), .wreg(wreg),
    .src(src), .nxt(pc_nxt)
  );

  pcx_pc_reg #(.PC_W(PC_W), .RST_VEC(RST_VEC)) u_pc (
    .clk(clk), .rst(rst), .nxt(pc_nxt), .q(pc_q)
  );

  assign pc_full    = pc_q;
  assign pc_lo      = pc_q[BYTE_W-1:0];
  assign fetch_addr = pc_q[MEM_AW-1:0];

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(pc_q));
  // R2
  step_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && !irq_take && !lo_we && !jmp_rel) |=> pc_q == PC_W'($past(pc_q) + 1'b1));
  // R9
  vec_load_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && irq_take) |=> pc_q == PC_W'(IRQ_VEC));
  // R6
  low_load_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && lo_we && !irq_take) |=> (pc_q[PC_W-1:BYTE_W] == $past(hi_buf)
                                       && pc_q[BYTE_W-1:0] == $past(lo_wdata)));
  // R8
  rel_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && jmp_rel && !lo_we && !irq_take)
      |=> pc_q == PC_W'($past(pc_q) + 1'b1 + $past(wreg)));
endmodule

// File: tb/pcx_program_counter_tb.sv
module pcx_program_counter_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        step_en, lo_we, hi_we, jmp_rel, irq_take;
  logic [7:0]  lo_wdata, wreg;
  logic [6:0]  hi_wdata;
  logic [14:0] pc_full;
  logic [7:0]  pc_lo;
  logic [12:0] fetch_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pcx_program_counter u_dut (
    .clk(clk), .rst(rst), .step_en(step_en), .lo_we(lo_we), .lo_wdata(lo_wdata),
    .hi_we(hi_we), .hi_wdata(hi_wdata), .jmp_rel(jmp_rel), .wreg(wreg),
    .irq_take(irq_take), .pc_full(pc_full), .pc_lo(pc_lo), .fetch_addr(fetch_addr)
  );

  task automatic idle_inputs();
    step_en = 0; lo_we = 0; hi_we = 0; jmp_rel = 0; irq_take = 0;
    lo_wdata = '0; hi_wdata = '0; wreg = '0;
  endtask

  task automatic chk(string tag, logic [14:0] act, logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one enabled cycle, then inputs return to idle; outputs sampled at the following negedge
  task automatic cyc(bit lw, logic [7:0] ld, bit hw, logic [6:0] hd,
                     bit br, logic [7:0] w, bit irq);
    step_en = 1; lo_we = lw; lo_wdata = ld; hi_we = hw; hi_wdata = hd;
    jmp_rel = br; wreg = w; irq_take = irq;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic load_pc(logic [14:0] a);
    cyc(0, 8'h00, 1, a[14:8], 0, 8'h00, 0);
    cyc(1, a[7:0], 0, 7'h00, 0, 8'h00, 0);
  endtask

  task automatic do_reset();
    rst = 1; idle_inputs();
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 pc", pc_full, 15'h0000);
    chk("R1 low", {7'h0, pc_lo}, 15'h0000);
    chk("R1 fetch", {2'b0, fetch_addr}, 15'h0000);
    cyc(1, 8'h21, 0, 7'h00, 0, 8'h00, 0);
    chk("R1 buffer zero", pc_full, 15'h0021);
  endtask

  task automatic t_step();
    load_pc(15'h0100);
    for (int i = 1; i <= 4; i++) begin
      cyc(0, 8'h00, 0, 7'h00, 0, 8'h00, 0);
      chk("R2 step", pc_full, 15'(15'h0100 + i));
    end
    repeat (3) @(negedge clk);
    chk("R2 hold", pc_full, 15'h0104);
  endtask

  task automatic t_buf_only();
    load_pc(15'h0200);
    cyc(0, 8'h00, 1, 7'h55, 0, 8'h00, 0);
    chk("R5 buffer write", pc_full, 15'h0201);
    cyc(1, 8'h3C, 0, 7'h00, 0, 8'h00, 0);
    chk("R6 load", pc_full, 15'h553C);
    chk("R11 low", {7'h0, pc_lo}, 15'h003C);
    chk("R4 fold", {2'b0, fetch_addr}, 15'h153C);
  endtask

  task automatic t_same_cycle();
    // buffer holds 55h from the previous scenario
    cyc(1, 8'h80, 1, 7'h12, 0, 8'h00, 0);
    chk("R7 old buffer", pc_full, 15'h5580);
    cyc(1, 8'h01, 0, 7'h00, 0, 8'h00, 0);
    chk("R7 new buffer", pc_full, 15'h1201);
  endtask

  task automatic t_jump();
    load_pc(15'h00F0);
    cyc(0, 8'h00, 0, 7'h00, 1, 8'h20, 0);
    chk("R8 jump", pc_full, 15'h0111);
    cyc(0, 8'h00, 0, 7'h00, 1, 8'h00, 0);
    chk("R8 zero index", pc_full, 15'h0112);
    load_pc(15'h7F80);
    cyc(0, 8'h00, 0, 7'h00, 1, 8'hFF, 0);
    chk("R8 R3 jump wrap", pc_full, 15'h0080);
  endtask

  task automatic t_wrap();
    load_pc(15'h7FFF);
    chk("R4 top fetch", {2'b0, fetch_addr}, 15'h1FFF);
    cyc(0, 8'h00, 0, 7'h00, 0, 8'h00, 0);
    chk("R3 wrap", pc_full, 15'h0000);
    load_pc(15'h2005);
    chk("R4 fold 2005", {2'b0, fetch_addr}, 15'h0005);
  endtask

  task automatic t_priority();
    load_pc(15'h3456);
    cyc(1, 8'h99, 1, 7'h22, 1, 8'h10, 1);
    chk("R9 vector wins", pc_full, 15'h0004);
    cyc(1, 8'h77, 0, 7'h00, 1, 8'h10, 0);
    chk("R10 low beats jump", pc_full, 15'h2277);
  endtask

  task automatic t_reset_mid();
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R1 mid reset", pc_full, 15'h0000);
    cyc(1, 8'h77, 0, 7'h00, 0, 8'h00, 0);
    chk("R1 buffer cleared", pc_full, 15'h0077);
  endtask

  initial begin
    rst = 1; idle_inputs();
    @(negedge clk);
    t_reset();
    t_step();
    t_buf_only();
    t_same_cycle();
    t_jump();
    t_wrap();
    t_priority();
    t_reset_mid();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule